// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and a carry-in in a single combinational step and returns the sum together with a carry-out. The operands are cut into a low part and an upper part. The low part is a plain ripple chain of full adders, and each full adder is made of two half adders.

The upper part is built twice. One copy assumes a carry of 0 coming in from below, and the other assumes a carry of 1. Both copies work at the same time as the low part. When the low part finishes, its carry-out picks one of the two ready results, so the upper bits never wait for a ripple from the low bits.

A parameter can cut the upper part further into equal segments. Each segment is duplicated in the same way and is picked by the carry from the segment below it. This gives a chained carry-select structure.

Top module: `carry_select_adder`

## Requirements
- R1: `{carry_out, result}` equals the 33-bit sum of `opnd_a`, `opnd_b` and `carry_in` for every input combination.
- R2: `result[15:0]` equals `opnd_a[15:0] + opnd_b[15:0] + carry_in` modulo 2^16, whatever the upper operand bits are.
- R3: `result[31:16]` equals `opnd_a[31:16] + opnd_b[31:16]` modulo 2^16 when the low 16-bit sum does not carry out, and that value plus one when it does.
- R4: `carry_out` is the carry from the upper addition that was selected: it is 1 exactly when the upper halves plus the low carry reach 2^16.
- R5: Adding 1 to all ones with `carry_in` = 0 gives `result` = 0 and `carry_out` = 1.
- R6: All ones plus 0 with `carry_in` = 1 gives `result` = 0 and `carry_out` = 1. This shows that the carry-in enters at bit 0.
- R7: Zero operands with `carry_in` = 0 give `result` = 0 and `carry_out` = 0.
- R8: With the segment width parameter `SEG_W` set to 8, the upper half becomes two selected segments. This build gives the same `result` and `carry_out` as the default build for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First addend |
| opnd_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | 32 | Sum modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The bench drives several pattern groups into the adder.

- **Zeros and ones:** All zeros, and all ones with a carry entering either as an operand bit or as `carry_in`. These patterns separate a correct full-length carry path from one that stops at the half boundary.
- **Half-boundary carries:** Operands whose low halves overflow and operands whose low halves do not. These show whether the low carry picks the +1 copy or the +0 copy of the upper half.
- **Carry-out source:** Patterns where only the upper halves overflow. These show whether the carry-out comes from the selected copy.
- **Pseudo-random operands:** These are applied to the default build and to the build with 8-bit segments, and both are checked against a behavioural sum. This catches faults in the bits of the ripple chains.

// File: rtl/carry_select_adder.sv
module carry_select_adder #(
  parameter int WIDTH = 32,
  parameter int LOW_W = 16,
  parameter int SEG_W = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int UP_W = WIDTH - LOW_W;
  localparam int NSEG = UP_W / SEG_W;

  logic [LOW_W:0] lc;
  logic [NSEG:0]  selc;

  assign lc[0] = carry_in;

  for (genvar i = 0; i < LOW_W; i++) begin : g_low
    logic h1_s, h1_c, h2_c;
    assign h1_s = opnd_a[i] ^ opnd_b[i];
    assign h1_c = opnd_a[i] & opnd_b[i];
    assign result[i] = h1_s ^ lc[i];
    assign h2_c = h1_s & lc[i];
    assign lc[i+1] = h1_c | h2_c;
  end

  assign selc[0] = lc[LOW_W];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int BASE = LOW_W + g * SEG_W;
    logic [SEG_W-1:0] hs, hc;
    logic [1:0][SEG_W:0] rc;
    logic [1:0][SEG_W-1:0] rs;

    for (genvar j = 0; j < SEG_W; j++) begin : g_ha
      assign hs[j] = opnd_a[BASE+j] ^ opnd_b[BASE+j];
      assign hc[j] = opnd_a[BASE+j] & opnd_b[BASE+j];
    end

    for (genvar k = 0; k < 2; k++) begin : g_copy
      assign rc[k][0] = (k == 1);
      for (genvar j = 0; j < SEG_W; j++) begin : g_bit
        assign rs[k][j] = hs[j] ^ rc[k][j];
        assign rc[k][j+1] = hc[j] | (hs[j] & rc[k][j]);
      end
    end

    assign result[BASE +: SEG_W] = selc[g] ? rs[1] : rs[0];
    assign selc[g+1] = selc[g] ? rc[1][SEG_W] : rc[0][SEG_W];

    always_comb begin
      // R3
      seg_copy_step_chk: assert (rs[1] == rs[0] + SEG_W'(1))
        else $error("copy with carry 1 is not copy with carry 0 plus one");
      // R4
      seg_carry_order_chk: assert (!rc[0][SEG_W] || rc[1][SEG_W])
        else $error("carry-0 copy carries out but carry-1 copy does not");
    end
  end

  assign carry_out = selc[NSEG];

  always_comb begin
    // R2
    low_half_sum_chk: assert ({lc[LOW_W], result[LOW_W-1:0]} ==
        {1'b0, opnd_a[LOW_W-1:0]} + {1'b0, opnd_b[LOW_W-1:0]} + {{LOW_W{1'b0}}, carry_in})
      else $error("low half sum wrong");
    // R1
    full_sum_chk: assert ({carry_out, result} ==
        {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in})
      else $error("full sum wrong");
  end
endmodule

// File: tb/carry_select_adder_test.sv
module carry_select_adder_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a, b, r0, r1;
  logic cin, co0, co1;
  int checks = 0, fails = 0, cycles = 0;
  logic done = 1'b0;

  carry_select_adder uut (.opnd_a(a), .opnd_b(b), .carry_in(cin), .result(r0), .carry_out(co0));
  carry_select_adder #(.SEG_W(8)) uut_seg (.opnd_a(a), .opnd_b(b), .carry_in(cin), .result(r1), .carry_out(co1));

  localparam int NV = 10;
  // {a, b, cin, expected cout, expected sum}
  localparam logic [97:0] TAB [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000},  // R7
    {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_0000},  // R5
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000},  // R6
    {32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 32'h0001_0000},  // R3
    {32'h1234_5678, 32'h1111_1111, 1'b0, 1'b0, 32'h2345_6789},  // R3
    {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_0000},  // R4
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 32'h8000_0000},  // R3
    {32'hFFFF_0000, 32'h0000_FFFF, 1'b1, 1'b1, 32'h0000_0000},  // R4
    {32'hABCD_8000, 32'h1234_8000, 1'b0, 1'b0, 32'hBE02_0000},  // R3
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF}   // R4
  };

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [31:0] na, input logic [31:0] nb, input logic nc);
    @(negedge clk);
    a = na; b = nb; cin = nc;
    #1;
  endtask

  initial begin
    logic [31:0] x, y;
    logic [32:0] ref_sum;
    logic [16:0] lo;
    a = '0; b = '0; cin = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 idle zero", {co0, r0}, 33'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TAB[i][97:66], TAB[i][65:34], TAB[i][33]);
      ref_sum = {1'b0, a} + {1'b0, b} + {32'h0, cin};
      chk("R1 table vs reference", {co0, r0}, ref_sum);
      chk("R3/R4 table literal", {co0, r0}, TAB[i][32:0]);
      chk("R8 segmented build", {co1, r1}, TAB[i][32:0]);
    end

    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    chk("R5 ones plus one", {co0, r0}, {1'b1, 32'h0});
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    chk("R6 carry-in ripple", {co0, r0}, {1'b1, 32'h0});

    apply(32'h5A5A_0003, 32'h0000_0004, 1'b1);
    chk("R2 low half", {16'h0, r0[15:0]}, 33'h8);
    apply(32'hFFFF_0003, 32'hFFFF_0004, 1'b1);
    chk("R2 low half ignores upper", {16'h0, r0[15:0]}, 33'h8);

    x = 32'h1357_9BDF;
    y = 32'h2468_ACE0;
    for (int i = 0; i < 300; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
      apply(x, y, x[3]);
      ref_sum = {1'b0, a} + {1'b0, b} + {32'h0, cin};
      lo = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'h0, cin};
      chk("R1 random", {co0, r0}, ref_sum);
      chk("R2 random low", {16'h0, r0[15:0]}, {17'h0, lo[15:0]});
      chk("R3 random upper", {17'h0, r0[31:16]},
          {17'h0, a[31:16] + b[31:16] + {15'h0, lo[16]}});
      chk("R8 random segmented", {co1, r1}, ref_sum);
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(posedge done) begin
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule